// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block turns one floating-point short-vector instruction into a stream of per-element micro-operations. The instruction arrives with its starting destination index and two source indices, a stride-select bit, a double-width flag, an operand-count code and a vector length. The block then emits one micro-op per element. Each micro-op carries the three register indices for that element, first and last markers, and a delayed-commit flag. Between elements each index steps by the stride, but only inside its own aligned group of eight registers. Any source index that sits in the scalar bank stays fixed for the whole run, so a single sequence can mix scalar and vector operands.

Both stream edges use valid/ready. An instruction is taken only while the block is idle, so `in_ready` is low from the cycle the first micro-op shows until the cycle after the last one is consumed. On the output side, back-pressure freezes the block: while `out_valid` is high and `out_ready` is low, every output holds its value. A micro-op counts as consumed on a rising edge where both `out_valid` and `out_ready` are high. The error flag is a plain level output.

Top module: `svec_seq`

## Requirements
- R1: An index is in the scalar bank when (index mod 32) < 8. A source in the scalar bank keeps the same value on every micro-op of a sequence.
- R2: The element step is 1 when `in_stride` is 0 and 2 when it is 1. The step is doubled when `in_wide` is 1, giving 2 or 4.
- R3: A stepped index keeps its bits above bit 2 (its aligned group of eight). Only bits 2:0 change, and they become (old bits 2:0 + step) mod 8.
- R4: `in_nops` selects the operand form. 0 is destination only: both sources are held. 1 is two-operand: src1 steps only if it is outside the scalar bank, and src2 is held. 2 and 3 are three-operand: src1 always steps, and src2 steps only if it is outside the scalar bank. The destination steps in every form.
- R5: The effective length is `in_vlen` clipped to the range 1..8: 0 becomes 1 and values above 8 become 8. A vector sequence emits exactly that many micro-ops. `out_first` is high on the first micro-op only and `out_last` on the final one only. The first micro-op is valid in the cycle after acceptance.
- R6: If the destination is in the scalar bank, or the effective length is 1, exactly one micro-op is emitted. It has `out_first` and `out_last` both high, carries the indices as given, and has `out_dcommit` low.
- R7: On every micro-op of a multi-element sequence, including the first, `out_dcommit` is high.
- R8: `err_scalar_dst` is high alongside the single micro-op when the destination is in the scalar bank and the effective length is greater than 1. In every other case it is low.
- R9: `in_ready` is high only when no micro-op is pending. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R10: While reset is active, and after it, `out_valid` and `err_scalar_dst` are low and `in_ready` is high. An active reset abandons a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, can take an instruction |
| in_dst | input | IDX_W | Starting destination index |
| in_src1 | input | IDX_W | Starting first-source index |
| in_src2 | input | IDX_W | Starting second-source index |
| in_stride | input | 1 | Stride select: 0 gives step 1, 1 gives step 2 |
| in_wide | input | 1 | Double-width elements, doubles the step |
| in_nops | input | 2 | Operand form (0 dst only, 1 two-operand, 2/3 three-operand) |
| in_vlen | input | LEN_W | Requested vector length |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| out_dst | output | IDX_W | Element destination index |
| out_src1 | output | IDX_W | Element first-source index |
| out_src2 | output | IDX_W | Element second-source index |
| out_first | output | 1 | First micro-op of the instruction |
| out_last | output | 1 | Final micro-op of the instruction |
| out_dcommit | output | 1 | Delayed-commit flag |
| err_scalar_dst | output | 1 | Vector request made with a scalar-bank destination |

## Verification
Two events can fall in the same cycle: the final micro-op draining on the output side, and a new instruction already waiting with `in_valid` high. The bench keeps the next instruction on the input for the whole run of the current one. It checks that `in_ready` stays low on every cycle that shows a micro-op, that exactly one idle cycle follows the last handshake, and that the next micro-op then appears with `out_first` set and the new indices. Output stalls are also made to land on the cycle that carries the last marker and on single-op error cases. In those cycles the held values are compared against the values seen one cycle earlier.

// File: rtl/svec_pkg.sv
package svec_pkg;

  typedef enum logic [1:0] {
    NOPS_DST     = 2'd0,
    NOPS_TWO     = 2'd1,
    NOPS_THREE   = 2'd2,
    NOPS_THREE_X = 2'd3
  } nops_e;

  localparam int LANES     = 3;
  localparam int LANE_DST  = 0;
  localparam int LANE_SRC1 = 1;
  localparam int LANE_SRC2 = 2;

endpackage

// File: rtl/svec_step.sv
// Advances one register index by a step while keeping it inside its aligned group.
module svec_step #(
  parameter int IDX_W = 6,
  parameter int GRP_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [GRP_W-1:0] step_i,
  input  logic             en_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [GRP_W-1:0] off_sum;

  // Carry out of the low field is discarded, which gives the wrap inside the group.
  assign off_sum = idx_i[GRP_W-1:0] + step_i;
  assign idx_o   = en_i ? {idx_i[IDX_W-1:GRP_W], off_sum} : idx_i;

endmodule

// File: rtl/svec_ctrl.sv
// Element counter and sequence state: length clipping, single-op decision, markers.
module svec_ctrl #(
  parameter int LEN_W    = 4,
  parameter int MAX_VLEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  input  logic [LEN_W-1:0] raw_len,
  input  logic             dst_scalar,
  input  logic             out_ready,
  output logic             busy,
  output logic             first,
  output logic             last,
  output logic             step_now,
  output logic             multi,
  output logic             err_flag
);

  logic [LEN_W-1:0] len_clip;
  logic [LEN_W-1:0] load_cnt;
  logic             vec_req;
  logic             single;
  logic [LEN_W-1:0] remain_q;
  logic             busy_q;
  logic             first_q;
  logic             multi_q;
  logic             err_q;
  logic             pop;

  always_comb begin
    if (raw_len == '0)
      len_clip = LEN_W'(1);
    else if (raw_len > LEN_W'(MAX_VLEN))
      len_clip = LEN_W'(MAX_VLEN);
    else
      len_clip = raw_len;
  end

  assign vec_req  = (len_clip > LEN_W'(1));
  assign single   = dst_scalar | ~vec_req;
  assign load_cnt = single ? LEN_W'(1) : len_clip;

  assign last     = (remain_q == LEN_W'(1));
  assign pop      = busy_q & out_ready;
  assign step_now = pop & ~last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      first_q  <= 1'b0;
      multi_q  <= 1'b0;
      err_q    <= 1'b0;
    end else if (in_fire) begin
      busy_q   <= 1'b1;
      remain_q <= load_cnt;
      first_q  <= 1'b1;
      multi_q  <= ~single;
      err_q    <= dst_scalar & vec_req;
    end else if (pop) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        remain_q <= remain_q - LEN_W'(1);
        first_q  <= 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign first    = first_q;
  assign multi    = multi_q;
  assign err_flag = err_q;

endmodule

// File: rtl/svec_seq.sv
// Short-vector register index sequencer, top level.
module svec_seq
  import svec_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int GRP_SZ   = 8,
  parameter int BANK_SZ  = 32,
  parameter int MAX_VLEN = 8,
  parameter int LEN_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_dst,
  input  logic [IDX_W-1:0] in_src1,
  input  logic [IDX_W-1:0] in_src2,
  input  logic             in_stride,
  input  logic             in_wide,
  input  logic [1:0]       in_nops,
  input  logic [LEN_W-1:0] in_vlen,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_dst,
  output logic [IDX_W-1:0] out_src1,
  output logic [IDX_W-1:0] out_src2,
  output logic             out_first,
  output logic             out_last,
  output logic             out_dcommit,
  output logic             err_scalar_dst
);

  localparam int GRP_W  = $clog2(GRP_SZ);
  localparam int BANK_W = $clog2(BANK_SZ);

  function automatic logic is_scalar(input logic [IDX_W-1:0] idx);
    return (idx[BANK_W-1:GRP_W] == '0);
  endfunction

  logic             in_fire;
  logic             busy;
  logic             first;
  logic             last;
  logic             step_now;
  logic             multi;
  logic             err_flag;
  logic [GRP_W-1:0] step_in;
  logic [GRP_W-1:0] step_q;
  nops_e            nops;

  logic [IDX_W-1:0] start_idx [LANES];
  logic             adv_in    [LANES];
  logic [IDX_W-1:0] cur_idx   [LANES];
  logic [IDX_W-1:0] nxt_idx   [LANES];
  logic             adv_q     [LANES];

  assign in_ready = ~busy;
  assign in_fire  = in_valid & in_ready;
  assign nops     = nops_e'(in_nops);

  // Element step: base 1 or 2, doubled for double-width elements.
  always_comb begin
    step_in = in_stride ? GRP_W'(2) : GRP_W'(1);
    if (in_wide)
      step_in = step_in << 1;
  end

  // Per-lane advance policy, taken from the operand form and the scalar bank.
  always_comb begin
    start_idx[LANE_DST]  = in_dst;
    start_idx[LANE_SRC1] = in_src1;
    start_idx[LANE_SRC2] = in_src2;
    adv_in[LANE_DST]     = 1'b1;
    unique case (nops)
      NOPS_DST: begin
        adv_in[LANE_SRC1] = 1'b0;
        adv_in[LANE_SRC2] = 1'b0;
      end
      NOPS_TWO: begin
        adv_in[LANE_SRC1] = ~is_scalar(in_src1);
        adv_in[LANE_SRC2] = 1'b0;
      end
      default: begin
        adv_in[LANE_SRC1] = 1'b1;
        adv_in[LANE_SRC2] = ~is_scalar(in_src2);
      end
    endcase
  end

  svec_ctrl #(
    .LEN_W    (LEN_W),
    .MAX_VLEN (MAX_VLEN)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fire    (in_fire),
    .raw_len    (in_vlen),
    .dst_scalar (is_scalar(in_dst)),
    .out_ready  (out_ready),
    .busy       (busy),
    .first      (first),
    .last       (last),
    .step_now   (step_now),
    .multi      (multi),
    .err_flag   (err_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      step_q <= '0;
    else if (in_fire)
      step_q <= step_in;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    svec_step #(
      .IDX_W (IDX_W),
      .GRP_W (GRP_W)
    ) u_step (
      .idx_i  (cur_idx[g]),
      .step_i (step_q),
      .en_i   (adv_q[g]),
      .idx_o  (nxt_idx[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_idx[g] <= '0;
        adv_q[g]   <= 1'b0;
      end else if (in_fire) begin
        cur_idx[g] <= start_idx[g];
        adv_q[g]   <= adv_in[g];
      end else if (step_now) begin
        cur_idx[g] <= nxt_idx[g];
      end
    end
  end

  assign out_valid      = busy;
  assign out_dst        = cur_idx[LANE_DST];
  assign out_src1       = cur_idx[LANE_SRC1];
  assign out_src2       = cur_idx[LANE_SRC2];
  assign out_first      = busy & first;
  assign out_last       = busy & last;
  assign out_dcommit    = busy & multi;
  assign err_scalar_dst = busy & err_flag;

endmodule

// File: rtl/svec_chk.sv
// Protocol and sequencing checks, attached to the sequencer top by bind.
module svec_chk #(
  parameter int IDX_W    = 6,
  parameter int GRP_SZ   = 8,
  parameter int BANK_SZ  = 32,
  parameter int MAX_VLEN = 8,
  parameter int LEN_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_dst,
  input logic [IDX_W-1:0] out_src1,
  input logic [IDX_W-1:0] out_src2,
  input logic             out_first,
  input logic             out_last,
  input logic             out_dcommit,
  input logic             err_scalar_dst
);

  localparam int GRP_W  = $clog2(GRP_SZ);
  localparam int BANK_W = $clog2(BANK_SZ);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst) && $stable(out_src1)
      && $stable(out_src2) && $stable(out_first) && $stable(out_last)
      && $stable(out_dcommit) && $stable(err_scalar_dst)); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9

  AST_ACCEPT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_first); // R5

  AST_GROUP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && !out_first
      && (out_dst[IDX_W-1:GRP_W] == $past(out_dst[IDX_W-1:GRP_W]))); // R3

  AST_SCALAR_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && (out_src2[BANK_W-1:GRP_W] == '0)
      |=> out_src2 == $past(out_src2)); // R1

  AST_DCOMMIT_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_first && out_last) |-> out_dcommit); // R7

  AST_SINGLE_NO_DCOMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_first && out_last |-> !out_dcommit); // R6

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_scalar_dst |-> out_valid && out_first && out_last
      && (out_dst[BANK_W-1:GRP_W] == '0)); // R8

endmodule

bind svec_seq svec_chk #(
  .IDX_W    (IDX_W),
  .GRP_SZ   (GRP_SZ),
  .BANK_SZ  (BANK_SZ),
  .MAX_VLEN (MAX_VLEN),
  .LEN_W    (LEN_W)
) u_chk (.*);

// File: tb/svec_seq_tb.sv
module svec_seq_tb;

  typedef struct packed {
    logic [5:0] dst;
    logic [5:0] s1;
    logic [5:0] s2;
    logic       stride;
    logic       wide;
    logic [1:0] nops;
    logic [3:0] vlen;
    logic [3:0] n;
    logic [5:0] fd;
    logic [5:0] f1;
    logic [5:0] f2;
    logic       err;
  } vec_t;

  localparam int NVEC = 11;
  // dst, s1, s2, stride, wide, nops, vlen | expected count, final dst/s1/s2, error
  localparam vec_t VEC [NVEC] = '{
    '{6'd8,  6'd16, 6'd24, 1'b0, 1'b0, 2'd2, 4'd4,  4'd4, 6'd11, 6'd19, 6'd27, 1'b0},
    '{6'd10, 6'd17, 6'd3,  1'b1, 1'b0, 2'd2, 4'd3,  4'd3, 6'd14, 6'd21, 6'd3,  1'b0},
    '{6'd14, 6'd22, 6'd0,  1'b1, 1'b1, 2'd1, 4'd3,  4'd3, 6'd14, 6'd22, 6'd0,  1'b0},
    '{6'd15, 6'd5,  6'd0,  1'b0, 1'b0, 2'd1, 4'd8,  4'd8, 6'd14, 6'd5,  6'd0,  1'b0},
    '{6'd40, 6'd9,  6'd33, 1'b0, 1'b1, 2'd0, 4'd5,  4'd5, 6'd40, 6'd9,  6'd33, 1'b0},
    '{6'd3,  6'd16, 6'd24, 1'b0, 1'b0, 2'd2, 4'd4,  4'd1, 6'd3,  6'd16, 6'd24, 1'b1},
    '{6'd9,  6'd17, 6'd25, 1'b0, 1'b0, 2'd2, 4'd1,  4'd1, 6'd9,  6'd17, 6'd25, 1'b0},
    '{6'd36, 6'd50, 6'd2,  1'b0, 1'b0, 2'd2, 4'd2,  4'd1, 6'd36, 6'd50, 6'd2,  1'b1},
    '{6'd16, 6'd20, 6'd28, 1'b0, 1'b0, 2'd2, 4'd0,  4'd1, 6'd16, 6'd20, 6'd28, 1'b0},
    '{6'd16, 6'd24, 6'd48, 1'b0, 1'b0, 2'd2, 4'd12, 4'd8, 6'd23, 6'd31, 6'd55, 1'b0},
    '{6'd24, 6'd12, 6'd20, 1'b1, 1'b0, 2'd3, 4'd2,  4'd2, 6'd26, 6'd14, 6'd22, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [5:0] in_dst = '0;
  logic [5:0] in_src1 = '0;
  logic [5:0] in_src2 = '0;
  logic       in_stride = 1'b0;
  logic       in_wide = 1'b0;
  logic [1:0] in_nops = '0;
  logic [3:0] in_vlen = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [5:0] out_dst;
  logic [5:0] out_src1;
  logic [5:0] out_src2;
  logic       out_first;
  logic       out_last;
  logic       out_dcommit;
  logic       err_scalar_dst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  svec_seq u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_dst         (in_dst),
    .in_src1        (in_src1),
    .in_src2        (in_src2),
    .in_stride      (in_stride),
    .in_wide        (in_wide),
    .in_nops        (in_nops),
    .in_vlen        (in_vlen),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_dst        (out_dst),
    .out_src1       (out_src1),
    .out_src2       (out_src2),
    .out_first      (out_first),
    .out_last       (out_last),
    .out_dcommit    (out_dcommit),
    .err_scalar_dst (err_scalar_dst)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit scal(input int idx);
    return (idx % 32) < 8;
  endfunction

  function automatic int adv(input int idx, input int st);
    return (idx / 8) * 8 + ((idx % 8 + st) % 8);
  endfunction

  function automatic int pack_out(input int d, input int a, input int b,
                                  input bit f, input bit l, input bit dc, input bit e);
    return (d << 16) | (a << 10) | (b << 4) | (int'(f) << 3) | (int'(l) << 2)
           | (int'(dc) << 1) | int'(e);
  endfunction

  function automatic int dut_out();
    return pack_out(out_dst, out_src1, out_src2, out_first, out_last, out_dcommit,
                    err_scalar_dst);
  endfunction

  task automatic drive_instr(input vec_t v);
    in_dst    = v.dst;
    in_src1   = v.s1;
    in_src2   = v.s2;
    in_stride = v.stride;
    in_wide   = v.wide;
    in_nops   = v.nops;
    in_vlen   = v.vlen;
  endtask

  // One table entry: accept, then drain under a stall pattern with per-element checks.
  task automatic run_vec(input vec_t v, input int id);
    int  ed = v.dst;
    int  e1 = v.s1;
    int  e2 = v.s2;
    int  st = (v.stride ? 2 : 1) * (v.wide ? 2 : 1);
    int  k = 0;
    int  cyc = 0;
    int  saved = 0;
    int  last_seen = 0;
    bit  done = 1'b0;
    bit  stall_prev = 1'b0;
    @(negedge clk);
    drive_instr(v);
    in_valid = 1'b1;
    out_ready = 1'b0;
    #1 chk(in_ready == 1'b1, "R9", "idle in_ready before accept", in_ready, 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    while (!done) begin
      @(negedge clk);
      out_ready = ((cyc + id) % 3) != 0;
      cyc++;
      #1;
      if (stall_prev)
        chk(dut_out() == saved, "R9", "outputs held under stall", dut_out(), saved);
      if (!out_valid) begin
        chk(1'b0, "R5", "out_valid dropped mid-sequence", 0, 1);
        done = 1'b1;
      end else begin
        chk(in_ready == 1'b0, "R9", "in_ready while micro-op pending", in_ready, 0);
        if (out_ready) begin
          // R1 R2 R3 R4 R5 R6 R7 R8: full element tuple against the requirement model
          chk(dut_out() == pack_out(ed, e1, e2, k == 0, k == int'(v.n) - 1, v.n > 1, v.err),
              "R1/R2/R3/R4/R5/R6/R7/R8", $sformatf("vec %0d element %0d", id, k),
              dut_out(), pack_out(ed, e1, e2, k == 0, k == int'(v.n) - 1, v.n > 1, v.err));
          last_seen = pack_out(out_dst, out_src1, out_src2, 0, 0, 0, 0);
          if (out_last) done = 1'b1;
          k++;
          if (v.n > 1) begin
            ed = adv(ed, st);
            if (v.nops == 2'd1) begin
              if (!scal(e1)) e1 = adv(e1, st);
            end else if (v.nops >= 2'd2) begin
              e1 = adv(e1, st);
              if (!scal(e2)) e2 = adv(e2, st);
            end
          end
          stall_prev = 1'b0;
        end else begin
          saved = dut_out();
          stall_prev = 1'b1;
        end
      end
      if (cyc > 60) done = 1'b1;
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(k == int'(v.n), "R5", $sformatf("vec %0d micro-op count", id), k, v.n);
    chk(last_seen == pack_out(v.fd, v.f1, v.f2, 0, 0, 0, 0), "R3",
        $sformatf("vec %0d final indices", id), last_seen,
        pack_out(v.fd, v.f1, v.f2, 0, 0, 0, 0));
    #1 chk(out_valid == 1'b0 && in_ready == 1'b1, "R9",
           $sformatf("vec %0d idle after last", id), {out_valid, in_ready}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hist [8];
    vec_t a;
    vec_t b;
    repeat (3) @(negedge clk);
    #1 chk(out_valid == 1'b0 && in_ready == 1'b1 && err_scalar_dst == 1'b0, "R10",
           "state during reset", {out_valid, in_ready, err_scalar_dst}, 3'b010);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk(out_valid == 1'b0 && in_ready == 1'b1 && err_scalar_dst == 1'b0, "R10",
           "state after reset", {out_valid, in_ready, err_scalar_dst}, 3'b010);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i], i);

    // R9: next instruction waits on the input while the current one drains
    a = '{6'd8,  6'd0, 6'd0, 1'b0, 1'b0, 2'd0, 4'd3, 4'd3, 6'd10, 6'd0, 6'd0, 1'b0};
    b = '{6'd16, 6'd0, 6'd0, 1'b0, 1'b0, 2'd0, 4'd2, 4'd2, 6'd17, 6'd0, 6'd0, 1'b0};
    @(negedge clk);
    drive_instr(a);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(posedge clk);
    #1 drive_instr(b);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      #1 hist[c] = {in_ready, out_valid, out_first, out_last} | (int'(out_dst) << 4);
      if (c == 5) in_valid = 1'b0;
    end
    chk(hist[0] == ((8 << 4) | 4'b0110), "R9", "pending cycle 1", hist[0], (8 << 4) | 4'b0110);
    chk(hist[1] == ((9 << 4) | 4'b0100), "R9", "pending cycle 2", hist[1], (9 << 4) | 4'b0100);
    chk(hist[2] == ((10 << 4) | 4'b0101), "R9", "pending last", hist[2], (10 << 4) | 4'b0101);
    chk(hist[3][3:2] == 2'b10, "R9", "idle gap before next accept", hist[3][3:2], 2);
    chk(hist[4] == ((16 << 4) | 4'b0110), "R9", "next instr first", hist[4], (16 << 4) | 4'b0110);
    chk(hist[5] == ((17 << 4) | 4'b0101), "R9", "next instr last", hist[5], (17 << 4) | 4'b0101);
    @(negedge clk);
    out_ready = 1'b0;

    // R10: reset in the middle of a long sequence
    a = '{6'd16, 6'd24, 6'd48, 1'b0, 1'b0, 2'd2, 4'd8, 4'd8, 6'd23, 6'd31, 6'd55, 1'b0};
    @(negedge clk);
    drive_instr(a);
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1 chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", "reset abandons sequence",
           {out_valid, in_ready}, 1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b0;
    #1 chk(out_valid == 1'b0 && err_scalar_dst == 1'b0, "R10", "idle after mid-run reset",
           {out_valid, err_scalar_dst}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule